// File: doc/BRIEF.md
# Balancing Switch Matrix Sequencer

This block drives the solid-state switch array that places one floating, isolated DC/DC converter across a single cell inside a series stack of battery modules. Each module has N series cells and N+1 shared cell taps. Each module also has a top/bottom switch pair that picks which module's terminals feed the converter. Four polarity switches, arranged as two pairs, set the orientation of the converter rails. Because neighbouring cells share a tap, every second cell sits on the rails with its terminals swapped. The block therefore picks the polarity pair from whether the cell number is odd or even.

A supervisory controller holds `go` high together with a module index and a cell number. The sequencer takes that selection only while it is idle. It opens every switch, waits a programmable dead time, closes the module pair and the polarity pair, and then closes the two cell taps. It reports the path as active only after all of these switches are closed. Dropping `go` or `enable`, or raising `fault`, releases every switch at the next clock edge. To move to a new target, the controller drops `go` for at least one cycle, so the full open-and-wait sequence runs again before anything closes.

Top module: `bal_switch_seq`

## Requirements
- R1: After reset, every cell tap, module and polarity drive is 0, and `path_active` and `sel_err` are 0.
- R2: When `go`, `enable` and a valid selection are present at a clock edge while idle, that edge is the sample edge. All drives stay 0 for the sample edge and for the following DEAD_CYCLES edges. The module pair and the polarity pair close at sample edge + DEAD_CYCLES + 1. The two cell taps close one edge later. `path_active` rises one edge after that.
- R3: Cell number k (1-based, 1..N) of module m (0-based) closes flat tap bits m*(N+1)+k-1 and m*(N+1)+k, and no other tap bit.
- R4: An odd cell number closes `pol_drv[1:0]`. An even cell number closes `pol_drv[3:2]`. Both pairs are never closed at the same time.
- R5: At most one module is connected at a time. `mod_top_drv` and `mod_bot_drv` both have bit m set for the selected module.
- R6: A module index of NUM_MODULES or more, or a cell number of 0 or above N, sets `sel_err` at the sample edge and leaves all switches open. The next valid sample clears `sel_err`.
- R7: Deasserting `enable` or asserting `fault` opens every switch and clears `path_active` at the next clock edge, whatever the sequence state.
- R8: Changes of `module_sel` and `cell_sel` after the sample edge do not alter the path that is finally closed.
- R9: Dropping `go` opens every switch at the next edge. The next request then passes through the full dead time again.
- R10: With NUM_MODULES = 1, the module pair drives are held at 0, so only the N+1 taps and the 4 polarity switches are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Master enable; low opens all switches |
| fault | input | 1 | Fault; high opens all switches |
| go | input | 1 | Connection request, level-sensitive |
| module_sel | input | MOD_W | Target module index, 0-based |
| cell_sel | input | CELL_W | Target cell number, 1-based |
| cell_tap_drv | output | NUM_MODULES*(CELLS_PER_MODULE+1) | Cell tap switch drives, module-major |
| mod_top_drv | output | NUM_MODULES | Module top switch drives |
| mod_bot_drv | output | NUM_MODULES | Module bottom switch drives |
| pol_drv | output | 4 | Polarity drives; [1:0] odd pair, [3:2] even pair |
| path_active | output | 1 | Registered: converter path fully closed |
| sel_err | output | 1 | Last sampled selection was out of range |

## Verification
The bench counts edges from the sample edge to confirm that nothing closes during the dead window. A design that skipped or shortened the wait would close the module or polarity pair too early and short across the shared taps. It checks the top cell and an even cell against exact tap and polarity vectors. An off-by-one tap map or a swapped parity would close the wrong pair of nodes. It also changes the selection inputs in the middle of a sequence, applies fault and enable drops during the dead time and while active, and sends cell 0 and one-past-last indices. A design that sampled continuously, released late, or closed switches on a bad index would show up in the drive vectors.

// File: rtl/bal_pkg.sv
package bal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_OPEN      = 3'd1,
      ST_DEAD      = 3'd2,
      ST_CLOSE_MP  = 3'd3,
      ST_CLOSE_TAP = 3'd4,
      ST_ACTIVE    = 3'd5
   } seq_state_e;

   localparam logic [3:0] POL_ODD  = 4'b0011;
   localparam logic [3:0] POL_EVEN = 4'b1100;

endpackage

// File: rtl/bal_sel_check.sv
module bal_sel_check #(
   parameter int NUM_MODULES      = 4,
   parameter int CELLS_PER_MODULE = 7,
   parameter int MOD_W            = 3,
   parameter int CELL_W           = 4
) (
   input  logic [MOD_W-1:0]  mod_idx,
   input  logic [CELL_W-1:0] cell_idx,
   output logic              sel_valid,
   output logic              cell_odd
);
   localparam logic [MOD_W-1:0]  MOD_LIMIT  = MOD_W'(NUM_MODULES);
   localparam logic [CELL_W-1:0] CELL_LIMIT = CELL_W'(CELLS_PER_MODULE);

   logic mod_ok;
   logic cell_ok;

   always_comb begin
      mod_ok    = (mod_idx < MOD_LIMIT);
      cell_ok   = (cell_idx != '0) && (cell_idx <= CELL_LIMIT);
      sel_valid = mod_ok && cell_ok;
      cell_odd  = cell_idx[0];
   end
endmodule

// File: rtl/bal_seq_fsm.sv
module bal_seq_fsm
   import bal_pkg::*;
#(
   parameter int DEAD_CYCLES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       fault,
   input  logic       go,
   input  logic       sel_valid,
   output seq_state_e state_q,
   output logic       sample_ok,
   output logic       sample_bad
);
   localparam int CNT_W = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEAD_CYCLES - 1);

   seq_state_e       state_d;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             abort;
   logic             request;

   always_comb begin
      request    = go && enable && !fault;
      abort      = !request;
      sample_ok  = (state_q == ST_IDLE) && request && sel_valid;
      sample_bad = (state_q == ST_IDLE) && request && !sel_valid;
   end

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (sample_ok) state_d = ST_OPEN;
         end
         ST_OPEN: begin
            cnt_d   = '0;
            state_d = ST_DEAD;
         end
         ST_DEAD: begin
            if (cnt_q == CNT_LAST) begin
               state_d = ST_CLOSE_MP;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_CLOSE_MP:  state_d = ST_CLOSE_TAP;
         ST_CLOSE_TAP: state_d = ST_ACTIVE;
         ST_ACTIVE:    state_d = ST_ACTIVE;
         default:      state_d = ST_IDLE;
      endcase
      if (abort && (state_q != ST_IDLE)) begin
         state_d = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end
endmodule

// File: rtl/bal_tap_decoder.sv
module bal_tap_decoder
   import bal_pkg::*;
#(
   parameter int NUM_MODULES      = 4,
   parameter int CELLS_PER_MODULE = 7,
   parameter int MOD_W            = 3,
   parameter int CELL_W           = 4
) (
   input  logic [MOD_W-1:0]                           mod_idx,
   input  logic [CELL_W-1:0]                          cell_idx,
   input  logic                                       cell_odd,
   input  logic                                       close_mp,
   input  logic                                       close_taps,
   output logic [NUM_MODULES*(CELLS_PER_MODULE+1)-1:0] taps,
   output logic [NUM_MODULES-1:0]                     mod_top,
   output logic [NUM_MODULES-1:0]                     mod_bot,
   output logic [3:0]                                 pol
);
   localparam int TAPS_PER_MOD = CELLS_PER_MODULE + 1;

   always_comb begin
      if (!close_mp)     pol = 4'b0000;
      else if (cell_odd) pol = POL_ODD;
      else               pol = POL_EVEN;
   end

   for (genvar m = 0; m < NUM_MODULES; m++) begin : g_mod
      logic hit_mod;
      assign hit_mod = (mod_idx == MOD_W'(m));

      if (NUM_MODULES == 1) begin : g_no_pair
         assign mod_top[m] = 1'b0;
         assign mod_bot[m] = 1'b0;
      end else begin : g_pair
         assign mod_top[m] = close_mp && hit_mod;
         assign mod_bot[m] = close_mp && hit_mod;
      end

      for (genvar j = 0; j < TAPS_PER_MOD; j++) begin : g_tap
         logic is_bottom;
         logic is_top;
         assign is_bottom = (cell_idx == CELL_W'(j + 1));
         assign is_top    = (cell_idx == CELL_W'(j));
         assign taps[m*TAPS_PER_MOD + j] = close_taps && hit_mod && (is_bottom || is_top);
      end
   end
endmodule

// File: rtl/bal_switch_seq.sv
module bal_switch_seq
   import bal_pkg::*;
#(
   parameter int NUM_MODULES      = 4,
   parameter int CELLS_PER_MODULE = 7,
   parameter int DEAD_CYCLES      = 3,
   localparam int MOD_W    = $clog2(NUM_MODULES + 1),
   localparam int CELL_W   = $clog2(CELLS_PER_MODULE + 2),
   localparam int NUM_TAPS = NUM_MODULES * (CELLS_PER_MODULE + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                fault,
   input  logic                go,
   input  logic [MOD_W-1:0]    module_sel,
   input  logic [CELL_W-1:0]   cell_sel,
   output logic [NUM_TAPS-1:0] cell_tap_drv,
   output logic [NUM_MODULES-1:0] mod_top_drv,
   output logic [NUM_MODULES-1:0] mod_bot_drv,
   output logic [3:0]          pol_drv,
   output logic                path_active,
   output logic                sel_err
);
   if (NUM_MODULES < 1) begin : g_bad_mod
      $error("NUM_MODULES must be at least 1");
   end
   if (CELLS_PER_MODULE < 2) begin : g_bad_cell
      $error("CELLS_PER_MODULE must be at least 2");
   end
   if (DEAD_CYCLES < 1) begin : g_bad_dead
      $error("DEAD_CYCLES must be at least 1");
   end

   seq_state_e          state_q;
   logic                sel_valid;
   logic                cell_odd_in;
   logic                sample_ok;
   logic                sample_bad;
   logic [MOD_W-1:0]    mod_q;
   logic [CELL_W-1:0]   cell_q;
   logic                odd_q;
   logic                close_mp;
   logic                close_taps;

   bal_sel_check #(
      .NUM_MODULES      (NUM_MODULES),
      .CELLS_PER_MODULE (CELLS_PER_MODULE),
      .MOD_W            (MOD_W),
      .CELL_W           (CELL_W)
   ) i_sel_check (
      .mod_idx   (module_sel),
      .cell_idx  (cell_sel),
      .sel_valid (sel_valid),
      .cell_odd  (cell_odd_in)
   );

   bal_seq_fsm #(
      .DEAD_CYCLES (DEAD_CYCLES)
   ) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .fault      (fault),
      .go         (go),
      .sel_valid  (sel_valid),
      .state_q    (state_q),
      .sample_ok  (sample_ok),
      .sample_bad (sample_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q       <= '0;
         cell_q      <= '0;
         odd_q       <= 1'b0;
         sel_err     <= 1'b0;
         path_active <= 1'b0;
      end else begin
         if (sample_ok) begin
            mod_q   <= module_sel;
            cell_q  <= cell_sel;
            odd_q   <= cell_odd_in;
            sel_err <= 1'b0;
         end else if (sample_bad) begin
            sel_err <= 1'b1;
         end
         path_active <= (state_q == ST_CLOSE_TAP || state_q == ST_ACTIVE)
                        && go && enable && !fault;
      end
   end

   always_comb begin
      close_mp   = (state_q == ST_CLOSE_MP) || (state_q == ST_CLOSE_TAP)
                   || (state_q == ST_ACTIVE);
      close_taps = (state_q == ST_CLOSE_TAP) || (state_q == ST_ACTIVE);
   end

   bal_tap_decoder #(
      .NUM_MODULES      (NUM_MODULES),
      .CELLS_PER_MODULE (CELLS_PER_MODULE),
      .MOD_W            (MOD_W),
      .CELL_W           (CELL_W)
   ) i_decoder (
      .mod_idx    (mod_q),
      .cell_idx   (cell_q),
      .cell_odd   (odd_q),
      .close_mp   (close_mp),
      .close_taps (close_taps),
      .taps       (cell_tap_drv),
      .mod_top    (mod_top_drv),
      .mod_bot    (mod_bot_drv),
      .pol        (pol_drv)
   );
endmodule

// File: rtl/bal_switch_seq_chk.sv
module bal_switch_seq_chk #(
   parameter int NUM_TAPS    = 32,
   parameter int NUM_MODULES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   enable,
   input logic                   fault,
   input logic [NUM_TAPS-1:0]    cell_tap_drv,
   input logic [NUM_MODULES-1:0] mod_top_drv,
   input logic [NUM_MODULES-1:0] mod_bot_drv,
   input logic [3:0]             pol_drv,
   input logic                   path_active,
   input logic                   sel_err
);
   logic all_open;
   assign all_open = (cell_tap_drv == '0) && (mod_top_drv == '0)
                     && (mod_bot_drv == '0) && (pol_drv == 4'b0000);

   // R2: once taps are closed they only ever open, never jump to another pair
   assert_taps_bbm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_tap_drv != '0) |=> ((cell_tap_drv == '0) || $stable(cell_tap_drv)));

   // R2: module pair likewise opens before a different module may close
   assert_mod_bbm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_top_drv != '0) |=> ((mod_top_drv == '0) || $stable(mod_top_drv)));

   // R2: active is reported only with the path closed
   assert_active_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      path_active |-> ((cell_tap_drv != '0) && (pol_drv != 4'b0000)));

   // R3: only a single cell's two taps can be closed
   assert_tap_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(cell_tap_drv) == 0) || ($countones(cell_tap_drv) == 2));

   // R4: the two polarity pairs are mutually exclusive and switch as pairs
   assert_pol_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_drv == 4'b0000) || (pol_drv == 4'b0011) || (pol_drv == 4'b1100));

   // R5: one module at most, top and bottom together
   assert_one_module_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mod_top_drv) && (mod_top_drv == mod_bot_drv));

   // R6: an error flag implies an open matrix
   assert_err_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err |-> all_open);

   // R7: disable or fault releases everything at the next edge
   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable || fault) |=> (all_open && !path_active));
endmodule

bind bal_switch_seq bal_switch_seq_chk #(
   .NUM_TAPS    (NUM_TAPS),
   .NUM_MODULES (NUM_MODULES)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .fault        (fault),
   .cell_tap_drv (cell_tap_drv),
   .mod_top_drv  (mod_top_drv),
   .mod_bot_drv  (mod_bot_drv),
   .pol_drv      (pol_drv),
   .path_active  (path_active),
   .sel_err      (sel_err)
);

// File: tb/test_bal_switch_seq.sv
module test_bal_switch_seq;
   localparam int NM   = 4;
   localparam int NC   = 7;
   localparam int DEAD = 3;
   localparam int MW   = $clog2(NM + 1);
   localparam int CW   = $clog2(NC + 2);
   localparam int NT   = NM * (NC + 1);

   localparam int S_NC = 3;
   localparam int S_CW = $clog2(S_NC + 2);
   localparam int S_NT = S_NC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic fault = 1'b0;
   logic go = 1'b0;
   logic [MW-1:0] module_sel = '0;
   logic [CW-1:0] cell_sel = '0;
   logic [NT-1:0] cell_tap_drv;
   logic [NM-1:0] mod_top_drv;
   logic [NM-1:0] mod_bot_drv;
   logic [3:0]    pol_drv;
   logic          path_active;
   logic          sel_err;

   logic              go_s = 1'b0;
   logic [0:0]        mod_s = '0;
   logic [S_CW-1:0]   cell_s = '0;
   logic [S_NT-1:0]   taps_s;
   logic [0:0]        mtop_s;
   logic [0:0]        mbot_s;
   logic [3:0]        pol_s;
   logic              act_s;
   logic              err_s;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bal_switch_seq #(
      .NUM_MODULES (NM), .CELLS_PER_MODULE (NC), .DEAD_CYCLES (DEAD)
   ) i_bal_switch_seq (
      .clk (clk), .rst_n (rst_n), .enable (enable), .fault (fault), .go (go),
      .module_sel (module_sel), .cell_sel (cell_sel),
      .cell_tap_drv (cell_tap_drv), .mod_top_drv (mod_top_drv),
      .mod_bot_drv (mod_bot_drv), .pol_drv (pol_drv),
      .path_active (path_active), .sel_err (sel_err)
   );

   bal_switch_seq #(
      .NUM_MODULES (1), .CELLS_PER_MODULE (S_NC), .DEAD_CYCLES (2)
   ) i_single (
      .clk (clk), .rst_n (rst_n), .enable (enable), .fault (fault), .go (go_s),
      .module_sel (mod_s), .cell_sel (cell_s),
      .cell_tap_drv (taps_s), .mod_top_drv (mtop_s),
      .mod_bot_drv (mbot_s), .pol_drv (pol_s),
      .path_active (act_s), .sel_err (err_s)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NT-1:0] exp_taps(input int m, input int c);
      logic [NT-1:0] v = '0;
      v[m*(NC+1) + c - 1] = 1'b1;
      v[m*(NC+1) + c]     = 1'b1;
      return v;
   endfunction

   function automatic logic [3:0] exp_pol(input int c);
      return (c % 2 == 1) ? 4'b0011 : 4'b1100;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_open(input string req);
      chk(req, {cell_tap_drv, mod_top_drv, mod_bot_drv, pol_drv}, '0);
      chk(req, path_active, 1'b0);
   endtask

   // full connect sequence; if scramble, selection inputs change after sampling
   task automatic run_connect(input int m, input int c, input bit scramble, input string req);
      logic [NM-1:0] mexp;
      mexp = '0;
      mexp[m] = 1'b1;
      module_sel = MW'(m);
      cell_sel   = CW'(c);
      go = 1'b1;
      step();                       // sample edge
      if (scramble) begin
         module_sel = MW'((m + 1) % NM);
         cell_sel   = CW'((c % NC) + 1);
      end
      chk_open({req, " R2 open after sample"});
      for (int i = 0; i < DEAD; i++) begin
         step();
         chk_open({req, " R2 dead window"});
      end
      step();
      chk({req, " R5 module pair"}, {mod_top_drv, mod_bot_drv}, {mexp, mexp});
      chk({req, " R4 polarity"}, pol_drv, exp_pol(c));
      chk({req, " R2 taps still open"}, cell_tap_drv, '0);
      step();
      chk({req, " R3 taps"}, cell_tap_drv, exp_taps(m, c));
      chk({req, " R2 not yet active"}, path_active, 1'b0);
      step();
      chk({req, " R2 active"}, path_active, 1'b1);
      chk({req, " R3 taps held"}, cell_tap_drv, exp_taps(m, c));
      chk({req, " R4 polarity held"}, pol_drv, exp_pol(c));
   endtask

   task automatic release_go(input string req);
      go = 1'b0;
      step();
      chk_open({req, " R9 release"});
   endtask

   task automatic t_reset();
      chk_open("R1 reset");
      chk("R1 reset err", sel_err, 1'b0);
   endtask

   task automatic t_odd_top();
      run_connect(3, NC, 1'b0, "R3 top cell");
      release_go("R9");
   endtask

   task automatic t_even();
      run_connect(1, 2, 1'b0, "R4 even cell");
      release_go("R9");
   endtask

   task automatic t_first();
      run_connect(0, 1, 1'b0, "R3 first cell");
      release_go("R9");
   endtask

   task automatic t_scramble();
      run_connect(2, 4, 1'b1, "R8 ignore late sel");
      release_go("R9");
   endtask

   task automatic t_range();
      module_sel = MW'(1);
      cell_sel   = '0;
      go = 1'b1;
      step();
      chk("R6 cell 0 err", sel_err, 1'b1);
      for (int i = 0; i < DEAD + 3; i++) begin
         step();
         chk_open("R6 cell 0 open");
      end
      module_sel = MW'(NM);
      cell_sel   = CW'(3);
      step();
      chk("R6 module limit err", sel_err, 1'b1);
      step();
      chk_open("R6 module limit open");
      module_sel = '0;
      cell_sel   = CW'(NC + 1);
      step();
      chk("R6 cell limit err", sel_err, 1'b1);
      chk_open("R6 cell limit open");
      cell_sel   = CW'(5);
      step();
      chk("R6 err cleared", sel_err, 1'b0);
      go = 1'b0;
      step();
   endtask

   task automatic t_enable_drop();
      run_connect(1, 5, 1'b0, "R7 pre");
      enable = 1'b0;
      step();
      chk_open("R7 enable low");
      go = 1'b0;
      enable = 1'b1;
      step();
   endtask

   task automatic t_fault_in_dead();
      module_sel = MW'(2);
      cell_sel   = CW'(6);
      go = 1'b1;
      step();
      step();                       // in dead window
      fault = 1'b1;
      step();
      chk_open("R7 fault in dead");
      for (int i = 0; i < DEAD + 3; i++) begin
         step();
         chk_open("R7 fault held");
      end
      go = 1'b0;
      fault = 1'b0;
      step();
   endtask

   task automatic t_fault_active();
      run_connect(0, 6, 1'b0, "R7 pre fault");
      fault = 1'b1;
      step();
      chk_open("R7 fault active");
      fault = 1'b0;
      go = 1'b0;
      step();
   endtask

   task automatic t_retarget();
      run_connect(3, 3, 1'b0, "R9 first");
      release_go("R9");
      run_connect(0, 4, 1'b0, "R9 retarget");
      release_go("R9");
   endtask

   task automatic t_single();
      cell_s = S_CW'(2);
      go_s = 1'b1;
      for (int i = 0; i < 10; i++) step();
      chk("R10 single taps", taps_s, 4'b0110);
      chk("R10 single module drives", {mtop_s, mbot_s}, 2'b00);
      chk("R10 single polarity", pol_s, 4'b1100);
      chk("R10 single active", act_s, 1'b1);
      go_s = 1'b0;
      step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      enable = 1'b1;
      step();
      t_reset();
      t_odd_top();
      t_even();
      t_first();
      t_scramble();
      t_range();
      t_enable_drop();
      t_fault_in_dead();
      t_fault_active();
      t_retarget();
      t_single();
      finish_run();
   end
endmodule